// File: doc/BRIEF.md
# Interrupt Event Capture Register Bank

This block is a small control and status register bank. It turns per-bit hardware event lines into sticky status flags and combines them into a single interrupt request. Each status bit watches its own event line for either a rising or a falling transition. The transition is found by comparing the line against a copy registered on the previous clock. Once set, a status bit is cleared by software in one of two ways, chosen per bit at elaboration time through a mode vector:
- automatically, by any valid read of the status register;
- explicitly, by writing a one into that bit's position of the status register.

Beside the status register sit three more registers:
- an enable register that decides which status bits may drive the interrupt;
- a configuration register that samples a hardware input once, on the first clock after reset;
- a strobe register whose written bits appear on outputs for exactly one clock.

Software reaches all four registers through a plain synchronous port. The port has a 2-bit address, read and write qualifiers, and combinational read data.

Top module: `irq_bank`

## Requirements
- R1: A synchronous active-low reset drives the status, enable and strobe registers to zero, so that the interrupt output is low and the strobe outputs are zero while reset is held.
- R2: Address 0 is the status register. Bit i takes its mode from MODES[2i+1:2i], where bit 2i set means falling edge and bit 2i+1 set means mask clear. The default MODES gives bit i mode i mod 4: mode 0 is rising/read-clear, 1 is falling/read-clear, 2 is rising/mask-clear and 3 is falling/mask-clear. A rising-mode bit sets one cycle after its event line goes from low to high.
- R3: A falling-mode bit sets one cycle after its event line goes from high to low. A transition in the opposite direction leaves it unchanged.
- R4: A read-clear bit clears on a cycle with the read qualifier high and address 0. Read data in that cycle shows the value before clearing. Writes to address 0 do not affect read-clear bits.
- R5: A mask-clear bit stays set across reads. It clears only when address 0 is written with a one in its position.
- R6: When a new edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: An event line level that is already present when reset is released is not counted as an edge.
- R8: Address 1 is the enable register and can be read and written. The interrupt output is high exactly when some status bit and its enable bit are both one.
- R9: Address 2 is the configuration register. On the first clock after reset release it loads the hardware configuration input. After that it can be read and written by software and no longer follows the input.
- R10: A write to address 3 drives the strobe outputs with the written data for exactly one clock, after which they return to zero. Address 3 reads back zero once the pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 configuration, 3 strobe |
| reg_wr | input | 1 | Write qualifier |
| reg_rd | input | 1 | Read qualifier (triggers read-clear) |
| reg_wdata | input | N | Write data |
| reg_rdata | output | N | Combinational read data of the selected register |
| hw_evt | input | N | Per-bit hardware event lines |
| hw_cfg_in | input | N | Value loaded into the configuration register after reset |
| hw_strobe | output | N | One-cycle strobe pulses written by software |
| irq | output | 1 | Interrupt request |

## Verification
Edge capture and software clearing can hit the same status bit in the same clock, and that collision is the case this block must get right. The bench provokes it for both clear types. It raises an event line at the same falling clock edge where it issues either a mask write to address 0 or a read of address 0. It then judges the outcome by reading the status register afterwards, where the bit must still be one. For the read case it also checks that the read data in the colliding cycle shows the value before the new edge.

// File: rtl/irq_bank.sv
`timescale 1ns/1ps
module irq_bank #(
  parameter int N = 8,
  parameter logic [2*N-1:0] MODES = 16'hE4E4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [N-1:0] reg_wdata,
  output logic [N-1:0] reg_rdata,
  input  logic [N-1:0] hw_evt,
  input  logic [N-1:0] hw_cfg_in,
  output logic [N-1:0] hw_strobe,
  output logic         irq
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_CFG  = 2'd2;
  localparam logic [1:0] A_STB  = 2'd3;

  logic [N-1:0] fall_sel, mask_sel;
  logic [N-1:0] stat_q, en_q, cfg_q, stb_q, evt_q;
  logic [N-1:0] set, clr;
  logic         first_q;

  for (genvar i = 0; i < N; i++) begin : g_mode
    assign fall_sel[i] = MODES[2*i];
    assign mask_sel[i] = MODES[2*i+1];
  end

  wire rd_stat = reg_rd && (reg_addr == A_STAT);
  wire wr_stat = reg_wr && (reg_addr == A_STAT);
  wire wr_en   = reg_wr && (reg_addr == A_EN);
  wire wr_cfg  = reg_wr && (reg_addr == A_CFG);
  wire wr_stb  = reg_wr && (reg_addr == A_STB);

  assign set = (hw_evt & ~evt_q & ~fall_sel) | (~hw_evt & evt_q & fall_sel);
  assign clr = (mask_sel & reg_wdata & {N{wr_stat}}) | (~mask_sel & {N{rd_stat}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      en_q    <= '0;
      cfg_q   <= '0;
      stb_q   <= '0;
      evt_q   <= hw_evt;
      first_q <= 1'b1;
    end else begin
      evt_q   <= hw_evt;
      first_q <= 1'b0;
      stat_q  <= set | (stat_q & ~clr);
      stb_q   <= wr_stb ? reg_wdata : '0;
      if (wr_en) en_q <= reg_wdata;
      if (first_q) cfg_q <= hw_cfg_in;
      else if (wr_cfg) cfg_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = stat_q;
      A_EN:    reg_rdata = en_q;
      A_CFG:   reg_rdata = cfg_q;
      default: reg_rdata = stb_q;
    endcase
  end

  assign hw_strobe = stb_q;
  assign irq = |(stat_q & en_q);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & $past(set)) == $past(set)));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> ((stat_q & ~mask_sel & ~$past(set)) == '0));

  a_r5_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !wr_stat) |=> ((stat_q & mask_sel & $past(stat_q)) == ($past(stat_q) & mask_sel)));

  a_r10_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_strobe != '0 && !wr_stb) |=> (hw_strobe == '0));

  a_r9_latch_first: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |=> (cfg_q == $past(hw_cfg_in)));

  a_r8_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0 && stat_q != '0));
endmodule

// File: tb/sim_irq_bank.sv
`timescale 1ns/1ps
module sim_irq_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [7:0] hw_evt = 8'hF0, hw_cfg_in = 8'hA5, hw_strobe;
  logic       irq;
  int vectors = 0, errors = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  irq_bank u0 (.clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata,
               .reg_rdata, .hw_evt, .hw_cfg_in, .hw_strobe, .irq);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, input logic [7:0] evt);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; hw_evt = evt;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [7:0] evt, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1; hw_evt = evt;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_evt(input logic [7:0] evt);
    @(negedge clk);
    hw_evt = evt;
  endtask

  task automatic clear_all();
    rd_reg(2'd0, hw_evt, v);
    wr_reg(2'd0, 8'hFF, hw_evt);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 strobe in reset", hw_strobe, 8'h00);
    chk("R1 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    hw_cfg_in = 8'h00;
    rd_reg(2'd0, hw_evt, v); chk("R7 no edge from reset level", v, 8'h00);
    rd_reg(2'd1, hw_evt, v); chk("R1 enable zero", v, 8'h00);
    rd_reg(2'd2, hw_evt, v); chk("R9 latched after reset", v, 8'hA5);
  endtask

  task automatic t_edges();
    set_evt(8'h0F);
    rd_reg(2'd0, hw_evt, v); chk("R2 R3 edges captured", v, 8'hA5);
    rd_reg(2'd0, hw_evt, v); chk("R4 R5 read-clear gone, mask kept", v, 8'h84);
    wr_reg(2'd0, 8'h04, hw_evt);
    rd_reg(2'd0, hw_evt, v); chk("R5 mask clears only bit 2", v, 8'h80);
    wr_reg(2'd0, 8'h80, hw_evt);
    set_evt(8'h00);
    rd_reg(2'd0, hw_evt, v); chk("R3 falling bits only", v, 8'h0A);
    rd_reg(2'd0, hw_evt, v); chk("R4 bit1 cleared by read", v, 8'h08);
    wr_reg(2'd0, 8'h08, hw_evt);
    set_evt(8'h01);
    wr_reg(2'd0, 8'h01, hw_evt);
    rd_reg(2'd0, hw_evt, v); chk("R4 write ignored on read-clear bit", v, 8'h01);
    rd_reg(2'd0, hw_evt, v); chk("R4 cleared after read", v, 8'h00);
  endtask

  task automatic t_collide();
    set_evt(8'h05);
    set_evt(8'h01);
    wr_reg(2'd0, 8'h04, 8'h05);
    rd_reg(2'd0, hw_evt, v); chk("R6 edge beats mask clear", v, 8'h04);
    set_evt(8'h04);
    rd_reg(2'd0, 8'h05, v); chk("R4 pre-clear value on read", v, 8'h04);
    rd_reg(2'd0, hw_evt, v); chk("R6 edge beats read clear", v, 8'h05);
    clear_all();
    rd_reg(2'd0, hw_evt, v); chk("R5 cleanup", v, 8'h00);
  endtask

  task automatic t_irq();
    set_evt(8'h45);
    @(negedge clk);
    chk("R8 irq off when disabled", {7'd0, irq}, 8'h00);
    wr_reg(2'd1, 8'h40, hw_evt);
    chk("R8 irq on when enabled", {7'd0, irq}, 8'h01);
    rd_reg(2'd1, hw_evt, v); chk("R8 enable readback", v, 8'h40);
    wr_reg(2'd1, 8'hBF, hw_evt);
    chk("R8 irq off other enables", {7'd0, irq}, 8'h00);
    clear_all();
  endtask

  task automatic t_cfg_strobe();
    wr_reg(2'd2, 8'h3C, hw_evt);
    rd_reg(2'd2, hw_evt, v); chk("R9 software write", v, 8'h3C);
    @(negedge clk);
    reg_addr = 2'd3; reg_wdata = 8'h81; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R10 strobe pulse", hw_strobe, 8'h81);
    @(negedge clk);
    chk("R10 strobe ended", hw_strobe, 8'h00);
    rd_reg(2'd3, hw_evt, v); chk("R10 strobe reads zero", v, 8'h00);
  endtask

  initial begin
    t_reset();
    t_edges();
    t_collide();
    t_irq();
    t_cfg_strobe();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule